// File: doc/BRIEF.md
# Page Translation Buffer

This block translates virtual addresses to physical addresses through a small, fully associative set of page mappings. Every lookup compares its virtual page number with all valid mappings at once. A registered response then reports one of three outcomes: a translation, a miss that system software must service, or a protection fault. Pages are 4 KB, so the low twelve address bits pass through unchanged and the upper twenty bits are replaced by a frame number.

Each mapping records read and write permission. It also holds two status bits: a touched flag and a modified flag. Software watches the touched flags epoch by epoch to approximate least-recently-used replacement. It uses the modified flags to skip writeback of clean pages. A maintenance port installs a mapping at an index chosen by software, drops a mapping, or wipes all touched flags at once. This port only acts when the caller runs in privileged mode. In user mode a maintenance request raises a fault instead.

Top module: `page_xlat_buffer`

## Requirements
- R1: A lookup whose page number equals that of a valid mapping with the needed permission returns `rs_hit`=1 and `rs_paddr` = {frame, address bits 11:0}. Every lookup response appears one cycle after the request, with `rs_valid`=1.
- R2: A lookup that matches no valid mapping returns `rs_miss`=1, `rs_hit`=0, `rs_prot`=0 and `rs_paddr`=0.
- R3: A lookup that matches a mapping but lacks the permission it needs (read permission when `lk_write`=0, write permission when `lk_write`=1) returns `rs_prot`=1, `rs_hit`=0 and `rs_paddr`=0. The mapping stays valid.
- R4: Any lookup that matches a mapping sets that mapping's bit in `touched_vec`, including a lookup that faults on permission. The bit is visible one cycle later.
- R5: A mapping's bit in `dirty_vec` is set only by a write lookup that hits it with write permission.
- R6: With `mt_op`=1 (install) in privileged mode, the mapping at `mt_index` becomes valid with the given page, frame and permissions, and its touched and dirty bits are cleared. Any other valid mapping holding the same page number is dropped in the same cycle.
- R7: With `mt_op`=2 (drop) in privileged mode, the mapping at `mt_index` becomes invalid.
- R8: With `mt_op`=3 (wipe) in privileged mode, every touched bit clears. A lookup match in the same cycle still leaves its own bit set.
- R9: Any nonzero `mt_op` with `priv_mode`=0 sets `mt_priv_fault` one cycle later and changes no mapping.
- R10: A lookup issued in the same cycle as a maintenance operation sees the mappings as they were before that operation.
- R11: After reset, all mappings are invalid and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| priv_mode | input | 1 | 1 when the caller runs privileged |
| mt_op | input | 2 | Maintenance: 0 none, 1 install, 2 drop, 3 wipe touched |
| mt_index | input | 3 | Mapping index for install or drop |
| mt_vpn | input | 20 | Virtual page number to install |
| mt_pfn | input | 20 | Frame number to install |
| mt_rd | input | 1 | Read permission to install |
| mt_wr | input | 1 | Write permission to install |
| rs_valid | output | 1 | Response present for last cycle's lookup |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No mapping matched |
| rs_prot | output | 1 | Permission fault |
| rs_paddr | output | 32 | Physical address when hit, else zero |
| mt_priv_fault | output | 1 | Last cycle's maintenance was refused in user mode |
| touched_vec | output | 8 | Touched bit of each mapping |
| dirty_vec | output | 8 | Modified bit of each mapping |

## Verification
The bench installs a page number that already sits at another index. A design that failed to drop the older copy would then hold two matches and return a frame ORed from both. It pairs a wipe of the touched bits with a lookup in the same cycle; a wrong priority would lose that lookup's touch. It also overwrites a mapping while looking up its old page. Pipelining the update into the lookup would turn the expected old hit into a miss. User-mode install attempts are followed by lookups and status reads that would expose any change that leaked through. Writes to read-only pages must fault without marking the page modified.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
    localparam int VA_W   = 32;
    localparam int PAGE_W = 12;
    localparam int VPN_W  = VA_W - PAGE_W;
    localparam int PFN_W  = 20;
    localparam int PA_W   = PFN_W + PAGE_W;
    localparam int N_ENT  = 8;

    typedef enum logic [1:0] {
        OP_NONE      = 2'd0,
        OP_FILL      = 2'd1,
        OP_DROP      = 2'd2,
        OP_WIPE      = 2'd3
    } maint_op_e;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             can_rd;
        logic             can_wr;
        logic             touched;
        logic             dirty;
    } map_ent_t;

    typedef struct packed {
        logic            vld;
        logic            hit;
        logic            miss;
        logic            prot;
        logic [PA_W-1:0] paddr;
    } xlat_rsp_t;

    function automatic logic access_ok(logic is_wr, logic can_rd, logic can_wr);
        return is_wr ? can_wr : can_rd;
    endfunction
endpackage

// File: rtl/pxb_cam.sv
module pxb_cam
    import pxb_pkg::*;
#(
    parameter int ENTRIES = N_ENT
) (
    input  map_ent_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]       key,
    output logic [ENTRIES-1:0]     match,
    output logic                   any,
    output logic [PFN_W-1:0]       sel_pfn,
    output logic                   sel_rd,
    output logic                   sel_wr
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = ents[i].valid && (ents[i].vpn == key);
    end

    assign any = |match;

    // at most one match is live, so an OR-reduction selects it
    always_comb begin
        sel_pfn = '0;
        sel_rd  = 1'b0;
        sel_wr  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                sel_pfn = sel_pfn | ents[i].pfn;
                sel_rd  = sel_rd  | ents[i].can_rd;
                sel_wr  = sel_wr  | ents[i].can_wr;
            end
        end
    end
endmodule

// File: rtl/pxb_store.sv
module pxb_store
    import pxb_pkg::*;
#(
    parameter int ENTRIES = N_ENT,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ENTRIES-1:0]     touch_set,
    input  logic [ENTRIES-1:0]     dirty_set,
    input  logic                   do_fill,
    input  logic                   do_drop,
    input  logic                   do_wipe,
    input  logic [IDX_W-1:0]       idx,
    input  logic [VPN_W-1:0]       new_vpn,
    input  logic [PFN_W-1:0]       new_pfn,
    input  logic                   new_rd,
    input  logic                   new_wr,
    input  logic [ENTRIES-1:0]     dup_match,
    output map_ent_t [ENTRIES-1:0] ents
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        map_ent_t ent_q;
        map_ent_t ent_d;
        logic     here;

        assign here = (idx == IDX_W'(i));

        always_comb begin
            ent_d = ent_q;
            if (do_wipe)      ent_d.touched = 1'b0;
            if (touch_set[i]) ent_d.touched = 1'b1;
            if (dirty_set[i]) ent_d.dirty   = 1'b1;
            if (do_fill && dup_match[i] && !here) ent_d.valid = 1'b0;
            if (do_fill && here) begin
                ent_d.valid   = 1'b1;
                ent_d.vpn     = new_vpn;
                ent_d.pfn     = new_pfn;
                ent_d.can_rd  = new_rd;
                ent_d.can_wr  = new_wr;
                ent_d.touched = 1'b0;
                ent_d.dirty   = 1'b0;
            end
            if (do_drop && here) ent_d.valid = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) ent_q <= '0;
            else     ent_q <= ent_d;
        end

        assign ents[i] = ent_q;
    end
endmodule

// File: rtl/pxb_resp.sv
module pxb_resp
    import pxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic              hit_any,
    input  logic              acc_ok,
    input  logic [PFN_W-1:0]  pfn,
    input  logic [PAGE_W-1:0] offset,
    input  logic              maint_bad,
    output xlat_rsp_t         rsp_q,
    output logic              bad_q
);
    xlat_rsp_t rsp_d;

    always_comb begin
        rsp_d.vld   = lk_valid;
        rsp_d.hit   = lk_valid && hit_any && acc_ok;
        rsp_d.miss  = lk_valid && !hit_any;
        rsp_d.prot  = lk_valid && hit_any && !acc_ok;
        rsp_d.paddr = rsp_d.hit ? {pfn, offset} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
            bad_q <= 1'b0;
        end else begin
            rsp_q <= rsp_d;
            bad_q <= maint_bad;
        end
    end
endmodule

// File: rtl/page_xlat_buffer.sv
module page_xlat_buffer
    import pxb_pkg::*;
#(
    parameter int ENTRIES = N_ENT,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic               lk_write,
    input  logic               priv_mode,
    input  logic [1:0]         mt_op,
    input  logic [IDX_W-1:0]   mt_index,
    input  logic [VPN_W-1:0]   mt_vpn,
    input  logic [PFN_W-1:0]   mt_pfn,
    input  logic               mt_rd,
    input  logic               mt_wr,
    output logic               rs_valid,
    output logic               rs_hit,
    output logic               rs_miss,
    output logic               rs_prot,
    output logic [PA_W-1:0]    rs_paddr,
    output logic               mt_priv_fault,
    output logic [ENTRIES-1:0] touched_vec,
    output logic [ENTRIES-1:0] dirty_vec
);
    map_ent_t [ENTRIES-1:0] ents;
    logic [ENTRIES-1:0]     lk_match;
    logic [ENTRIES-1:0]     dup_match;
    logic [ENTRIES-1:0]     valid_vec;
    logic                   lk_any, dup_any;
    logic [PFN_W-1:0]       lk_pfn, dup_pfn;
    logic                   lk_rd, lk_wr, dup_rd, dup_wr;
    logic                   acc_ok;
    maint_op_e              op;
    logic                   maint_req, maint_ok;
    xlat_rsp_t              rsp;

    assign op        = maint_op_e'(mt_op);
    assign maint_req = (op != OP_NONE);
    assign maint_ok  = maint_req && priv_mode;

    pxb_cam #(.ENTRIES(ENTRIES)) u_lk_cam (
        .ents(ents), .key(lk_vaddr[VA_W-1:PAGE_W]), .match(lk_match),
        .any(lk_any), .sel_pfn(lk_pfn), .sel_rd(lk_rd), .sel_wr(lk_wr)
    );

    pxb_cam #(.ENTRIES(ENTRIES)) u_dup_cam (
        .ents(ents), .key(mt_vpn), .match(dup_match),
        .any(dup_any), .sel_pfn(dup_pfn), .sel_rd(dup_rd), .sel_wr(dup_wr)
    );

    assign acc_ok = access_ok(lk_write, lk_rd, lk_wr);

    logic [ENTRIES-1:0] touch_set, dirty_set;
    assign touch_set = lk_valid ? lk_match : '0;
    assign dirty_set = (lk_valid && lk_write && acc_ok) ? lk_match : '0;

    pxb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst),
        .touch_set(touch_set), .dirty_set(dirty_set),
        .do_fill(maint_ok && op == OP_FILL),
        .do_drop(maint_ok && op == OP_DROP),
        .do_wipe(maint_ok && op == OP_WIPE),
        .idx(mt_index), .new_vpn(mt_vpn), .new_pfn(mt_pfn),
        .new_rd(mt_rd), .new_wr(mt_wr),
        .dup_match(dup_any ? dup_match : '0),
        .ents(ents)
    );

    pxb_resp u_resp (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .hit_any(lk_any),
        .acc_ok(acc_ok), .pfn(lk_pfn), .offset(lk_vaddr[PAGE_W-1:0]),
        .maint_bad(maint_req && !priv_mode),
        .rsp_q(rsp), .bad_q(mt_priv_fault)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_stat
        assign touched_vec[i] = ents[i].touched;
        assign dirty_vec[i]   = ents[i].dirty;
        assign valid_vec[i]   = ents[i].valid;
    end

    assign rs_valid = rsp.vld;
    assign rs_hit   = rsp.hit;
    assign rs_miss  = rsp.miss;
    assign rs_prot  = rsp.prot;
    assign rs_paddr = rsp.paddr;

    logic unused_sel;
    assign unused_sel = ^{dup_pfn, dup_rd, dup_wr};
endmodule

// File: rtl/pxb_checker.sv
module pxb_checker #(
    parameter int ENTRIES = 8,
    parameter int PAGE_W  = 12,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic               lk_write,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               priv_mode,
    input logic [1:0]         mt_op,
    input logic               rs_valid,
    input logic               rs_hit,
    input logic               rs_miss,
    input logic               rs_prot,
    input logic [PA_W-1:0]    rs_paddr,
    input logic               mt_priv_fault,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] dirty_vec
);
    assert_single_match_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    assert_resp_latency_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rs_valid == $past(lk_valid)));

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> (rs_paddr[PAGE_W-1:0] == $past(lk_vaddr[PAGE_W-1:0])));

    assert_miss_clean_R2: assert property (@(posedge clk) disable iff (rst)
        rs_miss |-> (!rs_hit && !rs_prot && rs_paddr == '0));

    assert_prot_clean_R3: assert property (@(posedge clk) disable iff (rst)
        rs_prot |-> (rs_valid && !rs_hit && rs_paddr == '0));

    assert_dirty_cause_R5: assert property (@(posedge clk) disable iff (rst)
        ((dirty_vec & ~$past(dirty_vec)) != '0) |-> $past(lk_valid && lk_write));

    assert_user_maint_R9: assert property (@(posedge clk) disable iff (rst)
        (mt_op != 2'd0 && !priv_mode) |=> (mt_priv_fault && $stable(valid_vec)));
endmodule

bind page_xlat_buffer pxb_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .priv_mode(priv_mode), .mt_op(mt_op),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss),
    .rs_prot(rs_prot), .rs_paddr(rs_paddr), .mt_priv_fault(mt_priv_fault),
    .lk_match(lk_match), .valid_vec(valid_vec), .dirty_vec(dirty_vec)
);

// File: tb/page_xlat_buffer_tb.sv
module page_xlat_buffer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        priv_mode = 1'b0;
    logic [1:0]  mt_op = '0;
    logic [2:0]  mt_index = '0;
    logic [19:0] mt_vpn = '0;
    logic [19:0] mt_pfn = '0;
    logic        mt_rd = 1'b0;
    logic        mt_wr = 1'b0;
    logic        rs_valid, rs_hit, rs_miss, rs_prot, mt_priv_fault;
    logic [31:0] rs_paddr;
    logic [7:0]  touched_vec, dirty_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_xlat_buffer u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .priv_mode(priv_mode), .mt_op(mt_op),
        .mt_index(mt_index), .mt_vpn(mt_vpn), .mt_pfn(mt_pfn),
        .mt_rd(mt_rd), .mt_wr(mt_wr), .rs_valid(rs_valid), .rs_hit(rs_hit),
        .rs_miss(rs_miss), .rs_prot(rs_prot), .rs_paddr(rs_paddr),
        .mt_priv_fault(mt_priv_fault), .touched_vec(touched_vec),
        .dirty_vec(dirty_vec)
    );

    typedef struct {
        logic [52:0] bits;  // vld,hit,miss,prot,fault,paddr,touched,dirty
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    bit          m_v[8], m_r[8], m_w[8], m_t[8], m_d[8];
    logic [19:0] m_vpn[8], m_pfn[8];

    function automatic logic [52:0] actual();
        return {rs_valid, rs_hit, rs_miss, rs_prot, mt_priv_fault,
                rs_paddr, touched_vec, dirty_vec};
    endfunction

    task automatic check(input string tag, input logic [52:0] got, input logic [52:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    // monitor: pops one expected item per cycle, a quarter period after the edge
    initial forever begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, actual(), e.bits);
        end
    end

    task automatic step(input bit lv, input logic [31:0] va, input bit wr,
                        input bit pm, input logic [1:0] op, input int idx,
                        input logic [19:0] vpn, input logic [19:0] pfn,
                        input bit r, input bit w, input string tag);
        exp_t e;
        int   hit_i = -1;
        bit   h = 0, ms = 0, pr = 0, ok = 0;
        logic [31:0] pa = '0;
        logic [7:0]  tv, dv;
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va; lk_write = wr; priv_mode = pm;
        mt_op = op; mt_index = 3'(idx); mt_vpn = vpn; mt_pfn = pfn;
        mt_rd = r; mt_wr = w;
        if (lv) for (int i = 0; i < 8; i++)
            if (m_v[i] && m_vpn[i] == va[31:12]) hit_i = i;
        if (lv) begin
            if (hit_i < 0) ms = 1;
            else begin
                ok = wr ? m_w[hit_i] : m_r[hit_i];
                if (ok) begin h = 1; pa = {m_pfn[hit_i], va[11:0]}; end
                else pr = 1;
            end
        end
        if (op == 2'd3 && pm) for (int i = 0; i < 8; i++) m_t[i] = 0;
        if (hit_i >= 0) begin
            m_t[hit_i] = 1;
            if (ok && wr) m_d[hit_i] = 1;
        end
        if (op == 2'd1 && pm) begin
            for (int i = 0; i < 8; i++)
                if (i != idx && m_v[i] && m_vpn[i] == vpn) m_v[i] = 0;
            m_v[idx] = 1; m_vpn[idx] = vpn; m_pfn[idx] = pfn;
            m_r[idx] = r; m_w[idx] = w; m_t[idx] = 0; m_d[idx] = 0;
        end
        if (op == 2'd2 && pm) m_v[idx] = 0;
        for (int i = 0; i < 8; i++) begin tv[i] = m_t[i]; dv[i] = m_d[i]; end
        e.bits = {lv, h, ms, pr, (op != 2'd0 && !pm), pa, tv, dv};
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic look(input logic [31:0] va, input bit wr, input string tag);
        step(1, va, wr, 0, 2'd0, 0, '0, '0, 0, 0, tag);
    endtask

    task automatic fill(input int idx, input logic [19:0] vpn, input logic [19:0] pfn,
                        input bit r, input bit w, input string tag);
        step(0, '0, 0, 1, 2'd1, idx, vpn, pfn, r, w, tag);
    endtask

    task automatic idle();
        step(0, '0, 0, 0, 2'd0, 0, '0, '0, 0, 0, "idle");
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog got=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_v[i] = 0; m_r[i] = 0; m_w[i] = 0; m_t[i] = 0; m_d[i] = 0;
            m_vpn[i] = '0; m_pfn[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset", actual(), '0);
        rst = 1'b0;

        look(32'h1234_5678, 0, "R11 empty lookup misses");
        fill(0, 20'h10001, 20'hA0001, 1, 1, "R6 fill 0");
        fill(1, 20'h10002, 20'hA0002, 1, 0, "R6 fill 1 read-only");
        fill(2, 20'h10003, 20'hA0003, 0, 1, "R6 fill 2 write-only");
        look(32'h1000_1ABC, 0, "R1 R4 read hit 0");
        look(32'h7777_7000, 0, "R2 miss");
        look(32'h1000_2004, 1, "R3 write to read-only");
        look(32'h1000_2FFF, 0, "R1 read read-only");
        look(32'h1000_3010, 0, "R3 read write-only");
        look(32'h1000_1F00, 1, "R5 write hit sets dirty");
        look(32'h1000_3123, 1, "R5 write to write-only");
        fill(5, 20'h10001, 20'hB0005, 1, 0, "R6 duplicate replaces 0");
        look(32'h1000_1004, 0, "R6 duplicate lookup");
        step(0, '0, 0, 1, 2'd2, 1, '0, '0, 0, 0, "R7 drop 1");
        look(32'h1000_2004, 0, "R7 dropped misses");
        step(1, 32'h1000_3000, 1, 1, 2'd3, 0, '0, '0, 0, 0, "R8 wipe with lookup");
        look(32'h1000_3000, 1, "R8 after wipe");
        step(0, '0, 0, 0, 2'd1, 2, 20'h20000, 20'hC0000, 1, 1, "R9 user fill");
        look(32'h1000_3040, 1, "R9 mapping unchanged");
        look(32'h2000_0040, 0, "R9 no new mapping");
        step(0, '0, 0, 0, 2'd3, 0, '0, '0, 0, 0, "R9 user wipe");
        step(0, '0, 0, 0, 2'd2, 5, '0, '0, 0, 0, "R9 user drop");
        look(32'h1000_1008, 0, "R9 drop refused");
        step(1, 32'h1000_3222, 1, 1, 2'd1, 2, 20'h30000, 20'hD0000, 1, 1,
             "R10 old hit during overwrite");
        look(32'h3000_0222, 0, "R10 new mapping next cycle");
        step(1, 32'h3000_0333, 0, 1, 2'd2, 2, '0, '0, 0, 0, "R10 hit during drop");
        look(32'h3000_0333, 0, "R10 miss after drop");
        for (int i = 0; i < 8; i++)
            fill(i, 20'h40000 + 20'(i), 20'hE0000 + 20'(i * 3), 1, (i % 2) == 0, "R6 fill all");
        for (int i = 0; i < 8; i++)
            look({20'h40000 + 20'(i), 12'(i * 17)}, 1, "R1 R3 sweep");
        step(1, 32'h4000_0000, 0, 1, 2'd3, 0, '0, '0, 0, 0, "R8 wipe sweep");
        idle();
        idle();
        repeat (3) @(posedge clk);
        done = 1'b1;
        report();
        $finish;
    end
endmodule